// File: doc/BRIEF.md
# Floating-Point Register List Transfer Sequencer

This block carries out a block move between a file of eight 80-bit extended-precision registers and memory. One 16-bit control word selects the direction, the stepping mode and an 8-bit register mask. For each selected register the sequencer issues one 12-byte extended-format element on a simple request/acknowledge memory port. A store takes four beats and a load takes three, and the element address steps by 12 bytes after each register.

A command is taken in the cycle when `cmd_valid_i` is high and the block is idle. The start address is the base address plus an optional signed 16-bit displacement, applied once. In the increment mode (mode 2) the mask is scanned from bit 0 up and bit i names register 7-i. In the decrement mode (mode 0) bit i names register i, and the address drops by 12 before each element is written. When the last element is complete, a one-cycle done pulse presents the final address. Combinations the block does not support raise a one-cycle unimplemented pulse instead.

Top module: `fp_list_xfer`

## Requirements
- R1: After reset, busy, done, unimplemented, memory request and register-file write are all low.
- R2: Control word bit 13 = 1 means registers to memory and 0 means memory to registers. Bits 12:11 give the mode (0 = decrement, 2 = increment) and bits 7:0 give the register mask.
- R3: Mask bits are served in ascending bit order. In mode 2, bit i maps to register 7-i; in mode 0, bit i maps to register i.
- R4: In mode 2, element n of a command (counting from 0) sits at start + 12n, and the final address is start + 12 times the number of set mask bits.
- R5: In mode 0 (stores only), the address drops by 12 before each element, and the final address is start - 12 times the number of set mask bits.
- R6: With `disp_mode_i` high, the start address is base + sign-extended `disp_i`, added once per command.
- R7: A store element makes four write beats in this order. (1) Offset 0, half size, wdata[15:0] = register bits 79:64 and upper wdata zero. (2) Offset 2, half size, data zero. (3) Offset 4, word size, register bits 63:32. (4) Offset 8, word size, register bits 31:0. `mem_size_o` is 0 for half and 1 for word.
- R8: A load element makes three read beats: offset 0 (half size; only rdata[15:0] is used), offset 4 (word) and offset 8 (word). Offset 2 is never read. The register then gets {rdata0[15:0], rdata4, rdata8} in one write-port pulse.
- R9: A load with a mode other than 2, or a store with mode 1 or 3, gives `unimpl_o` high for the one cycle after acceptance, with no bus beat, no register write and no done.
- R10: `done_o` pulses for one cycle after the final beat or register write. `addr_o` holds the final address while `done_o` is high.
- R11: A legal command with an all-zero mask raises `done_o` in the cycle after acceptance, with no bus traffic, and `addr_o` equals the start address.
- R12: While a request is waiting for acknowledge, the request, address, size and write data stay unchanged.
- R13: A command strobe while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_word_i | input | 16 | Control word: direction, mode, mask |
| base_addr_i | input | 32 | Base address |
| disp_mode_i | input | 1 | Apply displacement |
| disp_i | input | 16 | Signed displacement |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion pulse |
| unimpl_o | output | 1 | Unsupported command pulse |
| addr_o | output | 32 | Final address, valid with done |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_size_o | output | 1 | 0 half word, 1 word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data |
| rf_raddr_o | output | 3 | Register-file read index |
| rf_rdata_i | input | 80 | Register-file read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 3 | Register-file write index |
| rf_wdata_o | output | 80 | Register-file write data |

## Verification
The bench aims at the mask-to-register mapping, because a sequencer that ignored the mode would move the right data to mirrored registers in one of the two modes. It checks the decrement mode, since a design that subtracts after writing would shift every element by 12 bytes. It checks that a negative displacement is sign-extended and applied once, since the wrong handling shows up as a large or drifting address. It also checks that the pad half-word is written but never read. Zero masks, unsupported mode pairs, strobes while busy and randomly delayed acknowledges are covered so that an early done, a stray beat, or data changing while a request waits all show up as mismatches against the behavioural model.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_BEAT,
    ST_WRB
  } fpx_state_e;
endpackage

// File: rtl/fpx_decode.sv
module fpx_decode #(
  parameter int NREG = 8
) (
  input  logic [15:0]     word_i,
  output logic            to_mem_o,
  output logic            pre_o,
  output logic            legal_o,
  output logic [NREG-1:0] mask_o
);
  logic [1:0] mode;
  assign mode     = word_i[12:11];
  assign to_mem_o = word_i[13];
  assign pre_o    = (mode == 2'd0);
  // loads only step upward; stores may step either way
  assign legal_o  = to_mem_o ? (mode == 2'd0 || mode == 2'd2) : (mode == 2'd2);
  assign mask_o   = word_i[NREG-1:0];
endmodule

// File: rtl/fpx_mask_scan.sv
module fpx_mask_scan #(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0]         mask_i,
  input  logic                    pre_i,
  output logic                    found_o,
  output logic [$clog2(NREG)-1:0] reg_o,
  output logic [NREG-1:0]         mask_next_o
);
  localparam int IDX_W = $clog2(NREG);
  logic [IDX_W-1:0] pos;

  always_comb begin
    found_o = 1'b0;
    pos     = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        found_o = 1'b1;
        pos     = IDX_W'(i);
      end
    end
  end

  assign reg_o       = pre_i ? pos : IDX_W'(NREG - 1) - pos;
  assign mask_next_o = mask_i & (mask_i - NREG'(1));
endmodule

// File: rtl/fpx_beat_gen.sv
module fpx_beat_gen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEXP_W = 16
) (
  input  logic                         to_mem_i,
  input  logic [1:0]                   beat_i,
  input  logic [ADDR_W-1:0]            ea_i,
  input  logic [SEXP_W+2*DATA_W-1:0]   val_i,
  output logic [ADDR_W-1:0]            addr_o,
  output logic                         size_word_o,
  output logic [DATA_W-1:0]            wdata_o,
  output logic                         last_o
);
  localparam int REG_W = SEXP_W + 2 * DATA_W;
  localparam int W_B   = DATA_W / 8;
  logic [ADDR_W-1:0] off;

  always_comb begin
    off     = '0;
    wdata_o = '0;
    unique case (beat_i)
      2'd0: begin
        off = '0;
        if (to_mem_i) wdata_o = DATA_W'(val_i[REG_W-1 -: SEXP_W]);
      end
      2'd1: off = to_mem_i ? ADDR_W'(W_B / 2) : ADDR_W'(W_B);
      2'd2: begin
        off = to_mem_i ? ADDR_W'(W_B) : ADDR_W'(2 * W_B);
        if (to_mem_i) wdata_o = val_i[2*DATA_W-1 -: DATA_W];
      end
      default: begin
        off = ADDR_W'(2 * W_B);
        if (to_mem_i) wdata_o = val_i[DATA_W-1:0];
      end
    endcase
  end

  assign addr_o      = ea_i + off;
  assign size_word_o = to_mem_i ? beat_i[1] : (beat_i != 2'd0);
  assign last_o      = to_mem_i ? (beat_i == 2'd3) : (beat_i == 2'd2);
endmodule

// File: rtl/fp_list_xfer.sv
module fp_list_xfer
  import fpx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEXP_W = 16,
  parameter int NREG   = 8,
  parameter int DISP_W = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cmd_valid_i,
  input  logic [15:0]                     cmd_word_i,
  input  logic [ADDR_W-1:0]               base_addr_i,
  input  logic                            disp_mode_i,
  input  logic [DISP_W-1:0]               disp_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic                            unimpl_o,
  output logic [ADDR_W-1:0]               addr_o,
  output logic                            mem_req_o,
  output logic                            mem_we_o,
  output logic [ADDR_W-1:0]               mem_addr_o,
  output logic                            mem_size_o,
  output logic [DATA_W-1:0]               mem_wdata_o,
  input  logic                            mem_ack_i,
  input  logic [DATA_W-1:0]               mem_rdata_i,
  output logic [$clog2(NREG)-1:0]         rf_raddr_o,
  input  logic [SEXP_W+2*DATA_W-1:0]      rf_rdata_i,
  output logic                            rf_we_o,
  output logic [$clog2(NREG)-1:0]         rf_waddr_o,
  output logic [SEXP_W+2*DATA_W-1:0]      rf_wdata_o
);
  localparam int IDX_W  = $clog2(NREG);
  localparam int REG_W  = SEXP_W + 2 * DATA_W;
  localparam int STRIDE = (REG_W + SEXP_W) / 8;  // value plus pad half-word

  fpx_state_e        state_q;
  logic              to_mem_q, pre_q, done_q, unimpl_q;
  logic [NREG-1:0]   mask_q;
  logic [ADDR_W-1:0] addr_q, ea_q, start_addr;
  logic [1:0]        beat_q;
  logic [IDX_W-1:0]  reg_q;
  logic [REG_W-1:0]  hold_q;

  logic              dec_to_mem, dec_pre, dec_legal;
  logic [NREG-1:0]   dec_mask;
  logic              scan_found;
  logic [IDX_W-1:0]  scan_reg;
  logic [NREG-1:0]   scan_next;
  logic              beat_last;
  logic              accept;

  fpx_decode #(.NREG(NREG)) u_dec (
    .word_i   (cmd_word_i),
    .to_mem_o (dec_to_mem),
    .pre_o    (dec_pre),
    .legal_o  (dec_legal),
    .mask_o   (dec_mask)
  );

  fpx_mask_scan #(.NREG(NREG)) u_scan (
    .mask_i      (mask_q),
    .pre_i       (pre_q),
    .found_o     (scan_found),
    .reg_o       (scan_reg),
    .mask_next_o (scan_next)
  );

  fpx_beat_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEXP_W(SEXP_W)) u_beat (
    .to_mem_i    (to_mem_q),
    .beat_i      (beat_q),
    .ea_i        (ea_q),
    .val_i       (hold_q),
    .addr_o      (mem_addr_o),
    .size_word_o (mem_size_o),
    .wdata_o     (mem_wdata_o),
    .last_o      (beat_last)
  );

  assign accept     = cmd_valid_i && (state_q == ST_IDLE);
  assign start_addr = base_addr_i +
                      (disp_mode_i ? {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      to_mem_q <= 1'b0;
      pre_q    <= 1'b0;
      done_q   <= 1'b0;
      unimpl_q <= 1'b0;
      mask_q   <= '0;
      addr_q   <= '0;
      ea_q     <= '0;
      beat_q   <= '0;
      reg_q    <= '0;
      hold_q   <= '0;
    end else begin
      done_q   <= 1'b0;
      unimpl_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (!dec_legal) begin
            unimpl_q <= 1'b1;
          end else begin
            addr_q   <= start_addr;
            to_mem_q <= dec_to_mem;
            pre_q    <= dec_pre;
            mask_q   <= dec_mask;
            if (dec_mask == '0) done_q <= 1'b1;
            else                state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (scan_found) begin
            reg_q  <= scan_reg;
            mask_q <= scan_next;
            beat_q <= '0;
            if (pre_q) begin
              ea_q   <= addr_q - ADDR_W'(STRIDE);
              addr_q <= addr_q - ADDR_W'(STRIDE);
            end else begin
              ea_q   <= addr_q;
              addr_q <= addr_q + ADDR_W'(STRIDE);
            end
            if (to_mem_q) hold_q <= rf_rdata_i;
            state_q <= ST_BEAT;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_BEAT: if (mem_ack_i) begin
          if (!to_mem_q) begin
            unique case (beat_q)
              2'd0:    hold_q[REG_W-1 -: SEXP_W]    <= mem_rdata_i[SEXP_W-1:0];
              2'd1:    hold_q[2*DATA_W-1 -: DATA_W] <= mem_rdata_i;
              default: hold_q[DATA_W-1:0]           <= mem_rdata_i;
            endcase
          end
          if (beat_last) state_q <= to_mem_q ? ST_SCAN : ST_WRB;
          else           beat_q  <= beat_q + 2'd1;
        end
        default: state_q <= ST_SCAN;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign unimpl_o   = unimpl_q;
  assign addr_o     = addr_q;
  assign mem_req_o  = (state_q == ST_BEAT);
  assign mem_we_o   = to_mem_q;
  assign rf_raddr_o = scan_reg;
  assign rf_we_o    = (state_q == ST_WRB);
  assign rf_waddr_o = reg_q;
  assign rf_wdata_o = hold_q;

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_wdata_o) && $stable(mem_size_o)));

  assert_done_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_req_o && !rf_we_o && !unimpl_o));

  assert_zero_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec_legal && dec_mask == '0) |=> (done_o && !busy_o));

  assert_illegal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !dec_legal) |=> (unimpl_o && !busy_o && !done_o));

  assert_load_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (!mem_we_o && $past(mem_ack_i) && !mem_req_o));

  assert_busy_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i && !done_o) |=> !unimpl_o);
endmodule

// File: tb/fp_list_xfer_test.sv
module fp_list_xfer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [15:0] cmd_word_i = '0;
  logic [31:0] base_addr_i = '0;
  logic        disp_mode_i = 1'b0;
  logic [15:0] disp_i = '0;
  logic        busy_o, done_o, unimpl_o;
  logic [31:0] addr_o;
  logic        mem_req_o, mem_we_o, mem_size_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [2:0]  rf_raddr_o, rf_waddr_o;
  logic [79:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fp_list_xfer uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_word_i(cmd_word_i),
    .base_addr_i(base_addr_i), .disp_mode_i(disp_mode_i), .disp_i(disp_i),
    .busy_o(busy_o), .done_o(done_o), .unimpl_o(unimpl_o), .addr_o(addr_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_size_o(mem_size_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
  );

  function automatic logic [79:0] rf_val(input logic [2:0] r);
    return {16'h3FF0 + 16'(r), 32'hC0DE0000 + 32'(r), 32'h0000BEEF + (32'(r) << 8)};
  endfunction

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h5A5A};
  endfunction

  assign rf_rdata_i = rf_val(rf_raddr_o);

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected traffic
  logic [31:0] q_addr[$];
  logic        q_we[$];
  logic        q_word[$];
  logic [31:0] q_data[$];
  logic [2:0]  q_reg[$];
  logic [79:0] q_val[$];
  logic [31:0] exp_final;
  bit          exp_unimpl, exp_zero;

  task automatic push_beat(input logic [31:0] a, input logic we, input logic wd, input logic [31:0] d);
    q_addr.push_back(a); q_we.push_back(we); q_word.push_back(wd); q_data.push_back(d);
  endtask

  task automatic build_exp(input bit dir, input bit [1:0] mode, input bit [7:0] mask,
                           input logic [31:0] base, input bit dm, input logic [15:0] disp);
    logic [31:0] a, ea;
    logic [79:0] v;
    logic [31:0] f0, f4, f8;
    bit pre;
    a = base + (dm ? {{16{disp[15]}}, disp} : 32'd0);
    exp_unimpl = dir ? !(mode == 2'd0 || mode == 2'd2) : (mode != 2'd2);
    exp_zero = (mask == 8'd0);
    pre = (mode == 2'd0);
    if (!exp_unimpl) begin
      for (int i = 0; i < 8; i++) begin
        if (mask[i]) begin
          logic [2:0] r;
          r = pre ? 3'(i) : 3'(7 - i);
          if (pre) a = a - 32'd12;
          ea = a;
          if (dir) begin
            v = rf_val(r);
            push_beat(ea, 1'b1, 1'b0, {16'h0, v[79:64]});
            push_beat(ea + 32'd2, 1'b1, 1'b0, 32'h0);
            push_beat(ea + 32'd4, 1'b1, 1'b1, v[63:32]);
            push_beat(ea + 32'd8, 1'b1, 1'b1, v[31:0]);
          end else begin
            push_beat(ea, 1'b0, 1'b0, 32'h0);
            push_beat(ea + 32'd4, 1'b0, 1'b1, 32'h0);
            push_beat(ea + 32'd8, 1'b0, 1'b1, 32'h0);
            f0 = mem_f(ea); f4 = mem_f(ea + 32'd4); f8 = mem_f(ea + 32'd8);
            q_reg.push_back(r);
            q_val.push_back({f0[15:0], f4, f8});
          end
          if (!pre) a = a + 32'd12;
        end
      end
    end
    exp_final = a;
  endtask

  task automatic drive(input bit dir, input bit [1:0] mode, input bit [7:0] mask,
                       input logic [31:0] base, input bit dm, input logic [15:0] disp);
    @(negedge clk);
    cmd_word_i  = {2'b00, dir, mode, 3'b000, mask};
    base_addr_i = base;
    disp_mode_i = dm;
    disp_i      = disp;
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_end(input string req);
    int w;
    w = 0;
    while (!(done_o || unimpl_o) && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (exp_unimpl) begin
      chk(unimpl_o && !done_o && w == 0, "R9", {78'(w), unimpl_o, done_o}, {78'd0, 2'b10});
    end else begin
      chk(done_o && !unimpl_o, "R10", {done_o, unimpl_o}, 2'b10);
      chk(addr_o == exp_final, req, addr_o, exp_final);
      if (exp_zero) chk(w == 0, "R11", w, 0);
    end
    chk(q_addr.size() == 0 && q_reg.size() == 0, "R10",
        q_addr.size() + q_reg.size(), 0);
    @(negedge clk);
    chk(!done_o && !unimpl_o, "R10", {done_o, unimpl_o}, 2'b00);
  endtask

  task automatic run(input bit dir, input bit [1:0] mode, input bit [7:0] mask,
                     input logic [31:0] base, input bit dm, input logic [15:0] disp,
                     input string req);
    build_exp(dir, mode, mask, base, dm, disp);
    drive(dir, mode, mask, base, dm, disp);
    wait_end(req);
  endtask

  // memory responder with variable latency
  logic [7:0] lfsr = 8'hA7;
  int wait_cnt = 0;
  always @(posedge clk) begin
    #2;
    if (mem_req_o) begin
      if (wait_cnt == 0) begin
        mem_ack_i   = 1'b1;
        mem_rdata_i = mem_f(mem_addr_o);
        lfsr        = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wait_cnt    = int'(lfsr % 8'd3);
      end else begin
        wait_cnt--;
        mem_ack_i = 1'b0;
      end
    end else begin
      mem_ack_i = 1'b0;
    end
  end

  // per-clock comparison against the model
  bit          prev_pend = 1'b0;
  logic [31:0] prev_addr, prev_data;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_pend)
        chk(mem_req_o && mem_addr_o == prev_addr && mem_wdata_o == prev_data, "R12",
            {mem_addr_o, mem_wdata_o}, {prev_addr, prev_data});
      if (mem_req_o && mem_ack_i) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R3", mem_addr_o, 0);
        end else begin
          logic [31:0] ea, ed;
          logic ew, ez;
          ea = q_addr.pop_front(); ew = q_we.pop_front();
          ez = q_word.pop_front(); ed = q_data.pop_front();
          if (ew)
            chk(mem_we_o && mem_addr_o == ea && mem_size_o == ez && mem_wdata_o == ed, "R7",
                {mem_we_o, mem_size_o, mem_addr_o, mem_wdata_o}, {ew, ez, ea, ed});
          else
            chk(!mem_we_o && mem_addr_o == ea && mem_size_o == ez, "R8",
                {mem_we_o, mem_size_o, mem_addr_o}, {ew, ez, ea});
        end
      end
      if (rf_we_o) begin
        if (q_reg.size() == 0) begin
          chk(1'b0, "R8", rf_wdata_o, 0);
        end else begin
          logic [2:0] er;
          logic [79:0] ev;
          er = q_reg.pop_front(); ev = q_val.pop_front();
          chk(rf_waddr_o == er && rf_wdata_o == ev, "R3",
              {rf_waddr_o, rf_wdata_o}, {er, ev});
        end
      end
      prev_pend = mem_req_o && !mem_ack_i;
      prev_addr = mem_addr_o;
      prev_data = mem_wdata_o;
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !unimpl_o && !mem_req_o && !rf_we_o, "R1",
        {busy_o, done_o, unimpl_o, mem_req_o, rf_we_o}, 5'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !mem_req_o && !rf_we_o, "R1", {busy_o, mem_req_o, rf_we_o}, 3'b0);

    run(1'b1, 2'd2, 8'b0000_0101, 32'h0000_1000, 1'b0, 16'h0, "R4");   // R2 R3 R7
    run(1'b1, 2'd0, 8'b1000_0011, 32'h0000_2000, 1'b0, 16'h0, "R5");
    run(1'b1, 2'd2, 8'b1000_0000, 32'h0000_3000, 1'b1, 16'hFFF8, "R6");
    run(1'b1, 2'd0, 8'b0001_0000, 32'h0000_3000, 1'b1, 16'h0040, "R6");
    run(1'b0, 2'd2, 8'b1010_0001, 32'h0000_4000, 1'b0, 16'h0, "R8");
    run(1'b0, 2'd2, 8'b0000_0110, 32'h0000_5000, 1'b1, 16'h0010, "R6");
    run(1'b0, 2'd0, 8'b0000_0011, 32'h0000_6000, 1'b0, 16'h0, "R9");
    run(1'b0, 2'd1, 8'b0000_0011, 32'h0000_6000, 1'b0, 16'h0, "R9");
    run(1'b1, 2'd1, 8'b0000_0011, 32'h0000_6000, 1'b0, 16'h0, "R9");
    run(1'b1, 2'd3, 8'b1111_0000, 32'h0000_6000, 1'b0, 16'h0, "R9");
    run(1'b1, 2'd2, 8'b0000_0000, 32'h0000_7000, 1'b1, 16'hFFFC, "R11");
    run(1'b0, 2'd2, 8'b0000_0000, 32'h0000_7100, 1'b0, 16'h0, "R11");
    run(1'b1, 2'd2, 8'hFF, 32'h0000_8000, 1'b0, 16'h0, "R4");
    run(1'b1, 2'd0, 8'hFF, 32'h0000_9000, 1'b0, 16'h0, "R5");
    run(1'b0, 2'd2, 8'hFF, 32'h0000_A000, 1'b0, 16'h0, "R8");

    // R13: strobe during a transfer is ignored
    build_exp(1'b1, 2'd2, 8'b0100_0010, 32'h0000_B000, 1'b0, 16'h0);
    drive(1'b1, 2'd2, 8'b0100_0010, 32'h0000_B000, 1'b0, 16'h0);
    repeat (2) @(negedge clk);
    chk(busy_o, "R13", busy_o, 1);
    cmd_word_i  = {2'b00, 1'b0, 2'd2, 3'b000, 8'hFF};
    base_addr_i = 32'h0000_C000;
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    wait_end("R13");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule